// File: doc/BRIEF.md
# Memory-Mapped Serial Byte Port

This block sits between a processor's load/store bus and a pair of byte queues that carry serial traffic. One queue holds bytes arriving from the link (receive side) and the other holds bytes waiting to leave (transmit side). Software sees a handful of byte registers at fixed offsets from a base address. Two registers report status: data waiting on the receive side, and room left on the transmit side. A third register shows the oldest received byte without consuming it. Storing to a pop address discards that byte, and storing to a push address queues a byte for sending.

Before it reads, software polls the receive status byte. It then loads the data byte and stores any value to the pop address. Before it sends, software polls the transmit status byte and then stores the byte. The serialiser itself is not part of the block. The receive queue takes bytes through a plain push port, and the transmit queue gives them up through a plain pop port. Each queue is 16 entries deep by default.

Loads are registered. The byte a load returns appears on the read-data output one clock after the load strobe and reflects the state before that edge. Loads from any other address return zero.

Top module: `mmio_serial_port`

## Requirements
- R1: A load from offset 0 returns 0x01 when the receive queue holds at least one byte and 0x00 when it is empty; bits 7..1 are always zero.
- R2: A load from offset 1 returns the oldest receive byte (0x00 when the queue is empty) and leaves the queue unchanged, so repeated loads return the same byte.
- R3: A load from offset 2 returns 0x01 when the transmit queue has room for a byte and 0x00 when it is full; bits 7..1 are always zero.
- R4: A store of any data value to offset 4 is not the pop address; a store of any value to offset 3 removes the oldest receive byte.
- R5: A store to offset 4 appends the data byte to the transmit queue, which presents its oldest byte on the transmit data output and flags when it is empty.
- R6: Stores to offsets 0, 1 and 2 change no state in either queue.
- R7: A pop store when the receive queue is empty and a push store when the transmit queue is full are ignored and disturb no stored byte or ordering.
- R8: After reset both queues are empty, the receive status reads 0x00, the transmit status reads 0x01 and the read-data output is 0x00.
- R9: Each queue accepts exactly 16 bytes before it reports full and delivers bytes in arrival order.
- R10: Loads from offsets 3 through 7, or from outside the register window, return 0x00 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the load or store |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 8 | Store data byte |
| bus_rdata | output | 8 | Load result, valid the cycle after bus_rd |
| rx_in_valid | input | 1 | Push a byte into the receive queue |
| rx_in_data | input | 8 | Byte being pushed from the link side |
| rx_in_full | output | 1 | Receive queue full; pushes are dropped |
| tx_out_pop | input | 1 | Remove the oldest transmit byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| tx_out_empty | output | 1 | Transmit queue empty |

## Verification
A wrong queue pointer or count in this block shows up at the bus one cycle after the next load. The status byte flips at the wrong moment, or the data byte repeats, skips or reorders. A pop or push that is dropped or doubled shows within the same transaction on the transmit data output, or on the next data load on the receive side. Filling each queue past 16 entries and draining it in full brings out off-by-one errors in the full and empty flags. The same drain exposes corrupted ordering after ignored operations.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int BYTE_W    = 8;
    localparam int OFS_W     = 3;
    localparam int READY_BIT = 0;

    typedef enum logic [OFS_W-1:0] {
        OFS_RX_STAT = 3'd0,
        OFS_RX_DATA = 3'd1,
        OFS_TX_STAT = 3'd2,
        OFS_RX_POP  = 3'd3,
        OFS_TX_PUSH = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic rd_rx_stat;
        logic rd_rx_data;
        logic rd_tx_stat;
        logic wr_rx_pop;
        logic wr_tx_push;
    } bus_strobe_t;

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic                           empty,
    output logic                           full,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = st_q.cnt;
    assign head    = empty ? '0 : mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wp = (st_q.wp == PW'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wp] <= push_data;
        end
    end

endmodule

// File: rtl/serport_decode.sv
module serport_decode
    import serport_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_strobe_t       strb
);
    logic             in_window;
    logic [OFS_W-1:0] ofs;

    assign in_window = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
    assign ofs       = addr[OFS_W-1:0];

    always_comb begin
        strb = '0;
        if (in_window) begin
            strb.rd_rx_stat = rd && (ofs == OFS_RX_STAT);
            strb.rd_rx_data = rd && (ofs == OFS_RX_DATA);
            strb.rd_tx_stat = rd && (ofs == OFS_TX_STAT);
            strb.wr_rx_pop  = wr && (ofs == OFS_RX_POP);
            strb.wr_tx_push = wr && (ofs == OFS_TX_PUSH);
        end
    end

endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
    import serport_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h8000_0000,
    parameter int                 DEPTH     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_in_valid,
    input  logic [7:0]        rx_in_data,
    output logic              rx_in_full,
    input  logic              tx_out_pop,
    output logic [7:0]        tx_out_data,
    output logic              tx_out_empty
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } port_st_t;

    port_st_t    st_d, st_q;
    bus_strobe_t strb;

    logic [BYTE_W-1:0] rx_head;
    logic              rx_empty, rx_full;
    logic [CW-1:0]     rx_count;
    logic              tx_empty, tx_full;
    logic [CW-1:0]     tx_count;

    serport_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) i_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .strb (strb)
    );

    serport_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (DEPTH)
    ) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_in_valid),
        .push_data (rx_in_data),
        .pop       (strb.wr_rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full),
        .count     (rx_count)
    );

    serport_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (DEPTH)
    ) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (strb.wr_tx_push),
        .push_data (bus_wdata),
        .pop       (tx_out_pop),
        .head      (tx_out_data),
        .empty     (tx_empty),
        .full      (tx_full),
        .count     (tx_count)
    );

    always_comb begin
        st_d = '0;
        if (strb.rd_rx_stat) begin
            st_d.rdata[READY_BIT] = !rx_empty;
        end else if (strb.rd_rx_data) begin
            st_d.rdata = rx_head;
        end else if (strb.rd_tx_stat) begin
            st_d.rdata[READY_BIT] = !tx_full;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata    = st_q.rdata;
    assign rx_in_full   = rx_full;
    assign tx_out_empty = tx_empty;

endmodule

// File: rtl/serport_checker.sv
module serport_checker #(
    parameter int                 ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h8000_0000,
    parameter int                 DEPTH     = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_rd,
    input logic                       bus_wr,
    input logic [7:0]                 bus_rdata,
    input logic                       rx_in_valid,
    input logic                       tx_out_pop,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic [$clog2(DEPTH+1)-1:0] tx_count
);
    localparam int CW = $clog2(DEPTH+1);

    logic ld_rx_stat, ld_rx_data, ld_tx_stat, st_pop, st_push, st_ro;
    assign ld_rx_stat = bus_rd && (bus_addr == BASE_ADDR);
    assign ld_rx_data = bus_rd && (bus_addr == BASE_ADDR + ADDR_W'(1));
    assign ld_tx_stat = bus_rd && (bus_addr == BASE_ADDR + ADDR_W'(2));
    assign st_pop     = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(3));
    assign st_push    = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(4));
    assign st_ro      = bus_wr && (bus_addr == BASE_ADDR || bus_addr == BASE_ADDR + ADDR_W'(1)
                                   || bus_addr == BASE_ADDR + ADDR_W'(2));

    // R1
    rx_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rx_stat |=> bus_rdata == {7'b0, $past(rx_count) != '0});

    // R2
    rx_peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rx_data && !st_pop && !rx_in_valid) |=> rx_count == $past(rx_count));

    // R3
    tx_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_tx_stat |=> bus_rdata == {7'b0, $past(tx_count) != CW'(DEPTH)});

    // R4
    rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pop && rx_count != '0 && !rx_in_valid) |=> rx_count == $past(rx_count) - CW'(1));

    // R5
    tx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_push && tx_count != CW'(DEPTH) && !tx_out_pop) |=> tx_count == $past(tx_count) + CW'(1));

    // R6
    ro_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ro && !rx_in_valid && !tx_out_pop) |=> ($stable(rx_count) && $stable(tx_count)));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pop && rx_count == '0 && !rx_in_valid) |=> rx_count == '0);

    // R7
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_push && tx_count == CW'(DEPTH) && !tx_out_pop) |=> tx_count == CW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

endmodule

bind mmio_serial_port serport_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .DEPTH     (DEPTH)
) i_serport_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .rx_in_valid (rx_in_valid),
    .tx_out_pop  (tx_out_pop),
    .rx_count    (rx_count),
    .tx_count    (tx_count)
);

// File: tb/test_mmio_serial_port.sv
module test_mmio_serial_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h8000_0000;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_full;
    logic        tx_out_pop = 1'b0;
    logic [7:0]  tx_out_data;
    logic        tx_out_empty;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_serial_port i_mmio_serial_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rx_in_valid  (rx_in_valid),
        .rx_in_data   (rx_in_data),
        .rx_in_full   (rx_in_full),
        .tx_out_pop   (tx_out_pop),
        .tx_out_data  (tx_out_data),
        .tx_out_empty (tx_out_empty)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic store(input logic [31:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] v);
        @(negedge clk);
        rx_in_data  = v;
        rx_in_valid = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic tx_pop();
        @(negedge clk);
        tx_out_pop = 1'b1;
        @(negedge clk);
        tx_out_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R8 rdata after reset", bus_rdata, 8'h00);
        check("R8 tx empty after reset", {7'b0, tx_out_empty}, 8'h01);
        check("R8 rx not full after reset", {7'b0, rx_in_full}, 8'h00);
        load(BASE, d);        check("R8 R1 rx status", d, 8'h00);
        load(BASE + 2, d);    check("R8 R3 tx status", d, 8'h01);
        load(BASE + 1, d);    check("R2 empty data", d, 8'h00);
    endtask

    task automatic t_rx_peek_pop();
        logic [7:0] d;
        rx_push(8'hA5);
        rx_push(8'h3C);
        load(BASE, d);        check("R1 rx ready", d, 8'h01);
        load(BASE + 1, d);    check("R2 peek first", d, 8'hA5);
        load(BASE + 1, d);    check("R2 peek repeat", d, 8'hA5);
        store(BASE + 3, 8'hFF);
        load(BASE + 1, d);    check("R4 pop advances", d, 8'h3C);
        store(BASE + 3, 8'h00);
        load(BASE, d);        check("R4 R1 drained", d, 8'h00);
    endtask

    task automatic t_pop_empty();
        logic [7:0] d;
        store(BASE + 3, 8'h00);
        store(BASE + 3, 8'h00);
        rx_push(8'h77);
        load(BASE + 1, d);    check("R7 pop on empty ignored", d, 8'h77);
        store(BASE + 3, 8'h00);
        load(BASE, d);        check("R7 single entry drained", d, 8'h00);
    endtask

    task automatic t_ignored_stores();
        logic [7:0] d;
        rx_push(8'h11);
        rx_push(8'h22);
        store(BASE,     8'hFF);
        store(BASE + 1, 8'hFF);
        store(BASE + 2, 8'hFF);
        load(BASE + 1, d);    check("R6 rx head kept", d, 8'h11);
        check("R6 tx untouched", {7'b0, tx_out_empty}, 8'h01);
        store(BASE + 3, 8'h00);
        load(BASE + 1, d);    check("R6 rx order kept", d, 8'h22);
        store(BASE + 3, 8'h00);
    endtask

    task automatic t_tx_basic();
        store(BASE + 4, 8'h78);
        check("R5 tx not empty", {7'b0, tx_out_empty}, 8'h00);
        check("R5 tx head", tx_out_data, 8'h78);
        store(BASE + 4, 8'h9A);
        check("R5 head unchanged by second push", tx_out_data, 8'h78);
        tx_pop();
        check("R5 second byte", tx_out_data, 8'h9A);
        tx_pop();
        check("R5 tx empty again", {7'b0, tx_out_empty}, 8'h01);
    endtask

    task automatic t_tx_full();
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) store(BASE + 4, 8'(8'h40 + i));
        load(BASE + 2, d);    check("R9 R3 tx full after 16", d, 8'h00);
        store(BASE + 4, 8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            check("R9 R7 tx order", tx_out_data, 8'(8'h40 + i));
            tx_pop();
        end
        check("R7 overflow byte dropped", {7'b0, tx_out_empty}, 8'h01);
        load(BASE + 2, d);    check("R3 tx room again", d, 8'h01);
    endtask

    task automatic t_rx_full();
        logic [7:0] d;
        for (int i = 0; i < DEPTH - 1; i++) rx_push(8'(8'h80 + i));
        check("R9 rx not full at 15", {7'b0, rx_in_full}, 8'h00);
        rx_push(8'h8F);
        check("R9 rx full at 16", {7'b0, rx_in_full}, 8'h01);
        rx_push(8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            load(BASE + 1, d);
            check("R9 rx order", d, 8'(8'h80 + i));
            store(BASE + 3, 8'h00);
        end
        load(BASE, d);        check("R9 rx drained", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        rx_push(8'h5E);
        store(BASE + 4, 8'h6F);
        load(BASE + 3, d);    check("R10 pop addr reads zero", d, 8'h00);
        load(BASE + 4, d);    check("R10 push addr reads zero", d, 8'h00);
        load(BASE + 5, d);    check("R10 offset 5", d, 8'h00);
        load(BASE + 7, d);    check("R10 offset 7", d, 8'h00);
        load(32'h0000_0001, d); check("R10 outside window", d, 8'h00);
        load(BASE + 32'h8, d);  check("R10 next window", d, 8'h00);
        load(BASE + 1, d);    check("R10 loads consumed nothing", d, 8'h5E);
        check("R10 tx head kept", tx_out_data, 8'h6F);
        store(BASE + 3, 8'h00);
        tx_pop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_peek_pop();
        t_pop_empty();
        t_ignored_stores();
        t_tx_basic();
        t_tx_full();
        t_rx_full();
        t_unmapped();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule